// File: doc/BRIEF.md
# Interrupt In-Service and Serial Activity Status Register

This block keeps a read-only status byte that shows which interrupt priority level a processor is servicing, and whether each of two serial ports is sending or receiving. An interrupt controller reports each acknowledge with a level code. It also reports each return-from-interrupt. The block tracks three nested in-service levels: power-fail, high and low. A return ends the most urgent handler that is still open.

Each serial port drives strobes that mark the start and the end of a transmit frame and of a receive frame. The block turns these strobes into four activity bits. Their OR is a clock-divide inhibit signal. Clock-control logic uses this signal to refuse a divider change while a frame is in flight, because such a change would corrupt the data.

The block also raises a one-cycle nesting-error pulse when an acknowledge breaks the nesting rules.

Top module: `isr_status_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `status`, `div_inhibit` and `nest_err` are all 0.
- R2: An accepted acknowledge sets one in-service bit in the cycle after `ack_valid`. Level code 2 sets `status[7]` (power-fail), code 1 sets `status[6]` (high) and code 0 sets `status[5]` (low).
- R3: A `ret_pulse` clears only the highest in-service bit that is set, in the order bit 7, then bit 6, then bit 5. A return with no bit set changes nothing.
- R4: An acknowledge is rejected in three cases: its own bit is already set, a higher level's bit is set, or it carries level code 3. A rejected acknowledge leaves the in-service bits unchanged and drives `nest_err` high for exactly the following cycle.
- R5: When `ret_pulse` and `ack_valid` come in the same cycle, the return is applied first. The acknowledge is then judged against the bits left after the return.
- R6: Transmit activity sits in `status[3]` for port 1 and in `status[1]` for port 0. A `tx_start` strobe sets the bit in the next cycle and a `tx_done` strobe clears it. When both strobes come together, the bit ends up set.
- R7: Receive activity sits in `status[2]` for port 1 and in `status[0]` for port 0. It follows the same set, clear and collision rules as R6, using `rx_start` and `rx_done`.
- R8: `status[4]` always reads 0.
- R9: `div_inhibit` equals the OR of `status[3:0]` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ack_valid | input | 1 | Interrupt acknowledge strobe |
| ack_level | input | 2 | Level of the acknowledge: 0 low, 1 high, 2 power-fail, 3 invalid |
| ret_pulse | input | 1 | Return-from-interrupt strobe |
| tx_start | input | 2 | Per-port transmit start strobe, bit index = port |
| rx_start | input | 2 | Per-port receive start strobe |
| tx_done | input | 2 | Per-port transmit complete strobe |
| rx_done | input | 2 | Per-port receive complete strobe |
| status | output | 8 | Status byte |
| div_inhibit | output | 1 | Blocks clock-divide changes while any port is active |
| nest_err | output | 1 | One-cycle pulse for a rejected acknowledge |

## Verification
The bench builds the block with its defaults: three priority levels and two serial ports. This gives the full 8-bit layout, in which each port's bit pair and each level's bit can be checked at its fixed position.

Random traffic mixes acknowledges at all four level codes with returns and with colliding start and done strobes. This drives the tracker through deep nesting, repeated rejections and returns on an empty stack. Directed sequences pin down the return-before-acknowledge ordering and the case where start and done arrive together.

// File: rtl/isr_status_pkg.sv
package isr_status_pkg;

    localparam int unsigned LEVEL_CODE_W = 2;

    typedef enum logic [LEVEL_CODE_W-1:0] {
        LVL_LOW   = 2'd0,
        LVL_HIGH  = 2'd1,
        LVL_PFAIL = 2'd2,
        LVL_RSVD  = 2'd3
    } isr_level_e;

    typedef struct packed {
        logic busy;
    } chan_state_t;

endpackage

// File: rtl/isr_level_tracker.sv
module isr_level_tracker #(
    parameter int unsigned NUM_LEVELS = 3,
    parameter int unsigned CODE_W     = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ack_valid,
    input  logic [CODE_W-1:0]     ack_level,
    input  logic                  ret_pulse,
    output logic [NUM_LEVELS-1:0] inserv,
    output logic                  nest_err
);

    typedef struct packed {
        logic [NUM_LEVELS-1:0] inserv;
        logic                  err;
    } trk_state_t;

    trk_state_t state_d, state_q;
    logic [NUM_LEVELS-1:0] after_ret;
    logic                  blocked;
    logic                  code_bad;

    always_comb begin
        logic found;
        state_d      = state_q;
        state_d.err  = 1'b0;
        after_ret    = state_q.inserv;
        found        = 1'b0;
        // return: drop the highest open level only
        if (ret_pulse) begin
            for (int i = NUM_LEVELS - 1; i >= 0; i--) begin
                if (!found && after_ret[i]) begin
                    after_ret[i] = 1'b0;
                    found        = 1'b1;
                end
            end
        end
        code_bad = (32'(ack_level) >= NUM_LEVELS);
        blocked  = 1'b0;
        for (int j = 0; j < NUM_LEVELS; j++) begin
            if (32'(j) >= 32'(ack_level) && after_ret[j]) begin
                blocked = 1'b1;
            end
        end
        state_d.inserv = after_ret;
        if (ack_valid) begin
            if (code_bad || blocked) begin
                state_d.err = 1'b1;
            end else begin
                state_d.inserv[ack_level] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign inserv   = state_q.inserv;
    assign nest_err = state_q.err;

    AST_RET_DROPS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_pulse && !ack_valid && state_q.inserv[NUM_LEVELS-1]) |=> !inserv[NUM_LEVELS-1]); // R3

    AST_RET_KEEPS_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_pulse && !ack_valid && state_q.inserv[NUM_LEVELS-1]) |=>
        inserv[NUM_LEVELS-2:0] == $past(state_q.inserv[NUM_LEVELS-2:0])); // R3

    AST_BAD_CODE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && !ret_pulse && 32'(ack_level) >= NUM_LEVELS) |=> (nest_err && $stable(inserv))); // R4

    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (nest_err && !ack_valid) |=> !nest_err); // R4

    AST_ACK_LOW_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && !ret_pulse && ack_level == '0 && inserv == '0) |=> inserv[0]); // R2

endmodule

// File: rtl/isr_serial_channel.sv
module isr_serial_channel (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_start,
    input  logic tx_done,
    input  logic rx_start,
    input  logic rx_done,
    output logic tx_busy,
    output logic rx_busy
);
    import isr_status_pkg::*;

    chan_state_t tx_d, tx_q, rx_d, rx_q;

    always_comb begin
        tx_d = tx_q;
        rx_d = rx_q;
        // start wins over done: back-to-back frames
        if (tx_done)  tx_d.busy = 1'b0;
        if (tx_start) tx_d.busy = 1'b1;
        if (rx_done)  rx_d.busy = 1'b0;
        if (rx_start) rx_d.busy = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
            rx_q <= '0;
        end else begin
            tx_q <= tx_d;
            rx_q <= rx_d;
        end
    end

    assign tx_busy = tx_q.busy;
    assign rx_busy = rx_q.busy;

    AST_TX_START_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> tx_busy); // R6

    AST_TX_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && !tx_start) |=> !tx_busy); // R6

    AST_TX_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_done && !tx_start) |=> $stable(tx_busy)); // R6

    AST_RX_START_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_start |=> rx_busy); // R7

    AST_RX_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !rx_start) |=> !rx_busy); // R7

endmodule

// File: rtl/isr_status_top.sv
module isr_status_top #(
    parameter int unsigned NUM_LEVELS = 3,
    parameter int unsigned NUM_PORTS  = 2,
    localparam int unsigned CODE_W    = isr_status_pkg::LEVEL_CODE_W,
    localparam int unsigned ACT_W     = 2 * NUM_PORTS,
    localparam int unsigned STAT_W    = NUM_LEVELS + 1 + ACT_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ack_valid,
    input  logic [CODE_W-1:0]    ack_level,
    input  logic                 ret_pulse,
    input  logic [NUM_PORTS-1:0] tx_start,
    input  logic [NUM_PORTS-1:0] rx_start,
    input  logic [NUM_PORTS-1:0] tx_done,
    input  logic [NUM_PORTS-1:0] rx_done,
    output logic [STAT_W-1:0]    status,
    output logic                 div_inhibit,
    output logic                 nest_err
);

    logic [NUM_LEVELS-1:0] inserv;
    logic [ACT_W-1:0]      activity;

    isr_level_tracker #(
        .NUM_LEVELS (NUM_LEVELS),
        .CODE_W     (CODE_W)
    ) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .ack_valid (ack_valid),
        .ack_level (ack_level),
        .ret_pulse (ret_pulse),
        .inserv    (inserv),
        .nest_err  (nest_err)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        isr_serial_channel u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .tx_start (tx_start[p]),
            .tx_done  (tx_done[p]),
            .rx_start (rx_start[p]),
            .rx_done  (rx_done[p]),
            .tx_busy  (activity[2*p+1]),
            .rx_busy  (activity[2*p])
        );
    end

    assign status      = {inserv, 1'b0, activity};
    assign div_inhibit = |activity;

    AST_INHIBIT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div_inhibit) |-> $past(|(tx_start | rx_start))); // R9

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !status[ACT_W]); // R8

endmodule

// File: tb/sim_isr_status_top.sv
module sim_isr_status_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ack_valid = 1'b0;
    logic [1:0] ack_level = 2'd0;
    logic       ret_pulse = 1'b0;
    logic [1:0] tx_start = '0, rx_start = '0, tx_done = '0, rx_done = '0;
    logic [7:0] status;
    logic       div_inhibit;
    logic       nest_err;

    int n_vec = 0;
    int n_bad = 0;

    logic [2:0] m_inserv = '0;
    logic [1:0] m_tx = '0, m_rx = '0;
    logic       m_err = 1'b0;

    always #2.5 clk = ~clk;

    isr_status_top u0 (
        .clk(clk), .rst_n(rst_n), .ack_valid(ack_valid), .ack_level(ack_level),
        .ret_pulse(ret_pulse), .tx_start(tx_start), .rx_start(rx_start),
        .tx_done(tx_done), .rx_done(rx_done), .status(status),
        .div_inhibit(div_inhibit), .nest_err(nest_err)
    );

    function automatic logic [2:0] drop_top(input logic [2:0] v);
        if (v[2])      v[2] = 1'b0;
        else if (v[1]) v[1] = 1'b0;
        else if (v[0]) v[0] = 1'b0;
        return v;
    endfunction

    function automatic logic may_enter(input logic [2:0] v, input logic [1:0] lvl);
        if (lvl == 2'd3) return 1'b0;
        return (v >> lvl) == 3'b000;
    endfunction

    function automatic logic [1:0] chan_next(input logic [1:0] b, input logic [1:0] st,
                                             input logic [1:0] dn);
        return (b & ~dn) | st;
    endfunction

    task automatic cmp(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all(input string lvl_tag);
        cmp(lvl_tag, {5'd0, status[7:5]}, {5'd0, m_inserv});
        cmp("R8 reserved bit", {7'd0, status[4]}, 8'd0);
        cmp("R6 tx bits", {6'd0, status[3], status[1]}, {6'd0, m_tx});
        cmp("R7 rx bits", {6'd0, status[2], status[0]}, {6'd0, m_rx});
        cmp("R9 inhibit", {7'd0, div_inhibit}, {7'd0, |{m_tx, m_rx}});
        cmp("R4 nest_err", {7'd0, nest_err}, {7'd0, m_err});
    endtask

    task automatic step(input logic av, input logic [1:0] lv, input logic rp,
                        input logic [1:0] ts, input logic [1:0] rs,
                        input logic [1:0] td, input logic [1:0] rd, input string tag);
        logic [2:0] after;
        ack_valid = av; ack_level = lv; ret_pulse = rp;
        tx_start = ts; rx_start = rs; tx_done = td; rx_done = rd;
        after = rp ? drop_top(m_inserv) : m_inserv;
        m_err = 1'b0;
        if (av) begin
            if (may_enter(after, lv)) after[lv] = 1'b1;
            else m_err = 1'b1;
        end
        m_inserv = after;
        m_tx = chan_next(m_tx, ts, td);
        m_rx = chan_next(m_rx, rs, rd);
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check_all("R1 in-service reset");
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0, 0, 0, "R1 first cycle");
        // R2: nest upward through all levels
        step(1, 2'd0, 0, 0, 0, 0, 0, "R2 low");
        step(1, 2'd1, 0, 0, 0, 0, 0, "R2 high");
        step(1, 2'd2, 0, 0, 0, 0, 0, "R2 power-fail");
        // R4: same level and lower level rejected
        step(1, 2'd1, 0, 0, 0, 0, 0, "R4 lower while pf");
        step(1, 2'd2, 0, 0, 0, 0, 0, "R4 same level");
        step(1, 2'd3, 0, 0, 0, 0, 0, "R4 code 3");
        // R3: returns unwind in order, then empty return
        step(0, 0, 1, 0, 0, 0, 0, "R3 drop pf");
        step(0, 0, 1, 0, 0, 0, 0, "R3 drop high");
        step(0, 0, 1, 0, 0, 0, 0, "R3 drop low");
        step(0, 0, 1, 0, 0, 0, 0, "R3 empty return");
        // R5: return and acknowledge together
        step(1, 2'd0, 0, 0, 0, 0, 0, "R2 low again");
        step(1, 2'd0, 1, 0, 0, 0, 0, "R5 ret then low ack");
        step(1, 2'd1, 1, 0, 0, 0, 0, "R5 ret then high ack");
        step(0, 0, 1, 0, 0, 0, 0, "R3 drop high");
        // R6 / R7 directed
        step(0, 0, 0, 2'b01, 0, 0, 0, "R6 tx0 start");
        step(0, 0, 0, 2'b01, 0, 2'b01, 0, "R6 tx0 start+done");
        step(0, 0, 0, 0, 0, 2'b01, 0, "R6 tx0 done");
        step(0, 0, 0, 2'b10, 2'b10, 0, 0, "R7 port1 start");
        step(0, 0, 0, 0, 2'b01, 2'b10, 2'b10, "R7 rx swap");
        step(0, 0, 0, 0, 0, 0, 2'b01, "R9 idle drain");
        // constrained random
        for (int k = 0; k < 3000; k++) begin
            logic av, rp;
            logic [1:0] lv, ts, rs, td, rd;
            av = ($urandom % 4) == 0;
            lv = 2'($urandom % 4);
            rp = ($urandom % 4) == 0;
            ts = {($urandom % 7) == 0, ($urandom % 7) == 0};
            rs = {($urandom % 7) == 0, ($urandom % 7) == 0};
            td = {($urandom % 5) == 0, ($urandom % 5) == 0};
            rd = {($urandom % 5) == 0, ($urandom % 5) == 0};
            step(av, lv, rp, ts, rs, td, rd, "R2/R3 random in-service");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule